// File: doc/BRIEF.md
# Sound Channel High-Pass and Volume Output Stage

This block is the last digital stage of a four-channel tone generator. Each channel arrives as a single audio bit, already gated by its divider and noise logic. The first two channels can each go through a crude high-pass filter. The filter holds a sample of the channel bit and XORs that sample with the live bit. Channel 1 takes its sample on divider pulses from channel 3, and channel 2 takes its sample on pulses from channel 4. When the channel bit toggles much faster than the sampling pulses, it passes the filter. When it changes slowly, it mostly cancels.

Every channel then enters a volume gate. The gate drives a 4-bit level: the channel's volume field when the gated bit is 1, and 0 when it is 0. A per-channel force bit holds the gate input true. In that case the level is the volume field alone, which gives a volume-only output for sample playback.

Control state is held in five small registers that are written through an address, data and write-strobe port. Addresses 0 to 3 select the channel control registers. Address 4 selects the shared filter-enable register.

Top module: `snd_out_stage`

## Requirements
- R1: After reset every channel level is 0, all volume, force and filter-enable state is 0, and both filter sample flip-flops hold 0.
- R2: With the force bit clear and the gated audio bit 0, a channel's level is 0 whatever its volume field holds.
- R3: With the force bit clear, the gated audio bit 1 and no filter active, a channel's level equals its volume field. The volume field is bits 3..0 of the channel register, and channel c uses address c.
- R4: With the force bit (bit 4 of the channel register) set, the channel level equals the volume field. The audio bit, the divider pulses and the filter have no effect.
- R5: When bit 2 of the register at address 4 is set, channel 1 (index 0) is filtered. Its sample flip-flop loads the channel 1 audio bit on a clock edge where the channel 3 pulse (div_tick[2]) is high, and the gated bit is the live audio XOR the held sample.
- R6: When bit 1 of the register at address 4 is set, channel 2 (index 1) is filtered in the same way, sampled on the channel 4 pulse (div_tick[3]).
- R7: While a channel's filter enable is clear, its audio bypasses the filter and its sample flip-flop keeps its value, even across divider pulses. A later re-enable uses the held value.
- R8: Channels 3 and 4 have no filter. Their level depends only on their own audio bit, force bit and volume field.
- R9: A volume field of 0 gives level 0 even when forced, and a field of 15 gives level 15.
- R10: Writes to addresses 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ch_audio | input | 4 | Gated audio bit per channel, bit c for channel c+1 |
| div_tick | input | 4 | Single-cycle divider pulse per channel |
| ch_level | output | 16 | 4-bit output level per channel, channel c at bits 4c+3..4c |

## Verification
A wrong filter sample shows up at once as an inverted level on channel 1 or 2, on the first cycle that filter is enabled with a nonzero volume. The bench compares every channel on every step, so such a fault appears within one step of the pulse that caused it. A sample that was wrongly overwritten while its filter was disabled stays hidden until the filter is enabled again. The bench therefore re-enables the filter with no pulse present and checks the output directly. A wrong volume or force bit shows at the next sweep point, because each written setting is checked under both audio values.

// File: rtl/snd_out_pkg.sv
package snd_out_pkg;
  // bit positions in the channel control register
  localparam int FORCE_BIT = 4;
  // bit positions in the shared filter-enable register
  localparam int HPEN_A_BIT = 2;  // channel 1 filter
  localparam int HPEN_B_BIT = 1;  // channel 2 filter
  localparam int NUM_HP = 2;
endpackage

// File: rtl/snd_ctrl_regs.sv
module snd_ctrl_regs #(
  parameter int NUM_CH = 4,
  parameter int VOL_W  = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [NUM_CH*VOL_W-1:0] vol,
  output logic [NUM_CH-1:0]       force_on,
  output logic [snd_out_pkg::NUM_HP-1:0] hp_en
);
  import snd_out_pkg::*;
  localparam logic [ADDR_W-1:0] HPEN_ADDR = ADDR_W'(NUM_CH);

  logic [NUM_CH*VOL_W-1:0] vol_q, vol_d;
  logic [NUM_CH-1:0]       frc_q, frc_d;
  logic [NUM_HP-1:0]       hpen_q, hpen_d;
  logic                    unused_data;

  assign unused_data = ^wr_data[DATA_W-1:FORCE_BIT+1];

  always_comb begin
    vol_d  = vol_q;
    frc_d  = frc_q;
    hpen_d = hpen_q;
    if (wr_en) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_addr == ADDR_W'(c)) begin
          vol_d[c*VOL_W +: VOL_W] = wr_data[VOL_W-1:0];
          frc_d[c]                = wr_data[FORCE_BIT];
        end
      end
      if (wr_addr == HPEN_ADDR) begin
        hpen_d[0] = wr_data[HPEN_A_BIT];
        hpen_d[1] = wr_data[HPEN_B_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_q  <= '0;
      frc_q  <= '0;
      hpen_q <= '0;
    end else begin
      vol_q  <= vol_d;
      frc_q  <= frc_d;
      hpen_q <= hpen_d;
    end
  end

  assign vol      = vol_q;
  assign force_on = frc_q;
  assign hp_en    = hpen_q;
endmodule

// File: rtl/snd_hp_filter.sv
module snd_hp_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic audio_in,
  input  logic sample_tick,
  input  logic enable,
  output logic audio_out,
  output logic held
);
  logic held_q, held_d, load;

  assign load = enable & sample_tick;

  always_comb begin
    held_d = held_q;
    if (load) held_d = audio_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  assign audio_out = enable ? (audio_in ^ held_q) : audio_in;
  assign held      = held_q;
endmodule

// File: rtl/snd_vol_gate.sv
module snd_vol_gate #(
  parameter int VOL_W = 4
) (
  input  logic             audio_in,
  input  logic             force_on,
  input  logic [VOL_W-1:0] vol,
  output logic [VOL_W-1:0] level
);
  logic gate;
  assign gate  = audio_in | force_on;
  assign level = gate ? vol : '0;
endmodule

// File: rtl/snd_out_stage.sv
module snd_out_stage #(
  parameter int NUM_CH = 4,
  parameter int VOL_W  = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [NUM_CH-1:0]       ch_audio,
  input  logic [NUM_CH-1:0]       div_tick,
  output logic [NUM_CH*VOL_W-1:0] ch_level
);
  import snd_out_pkg::*;

  logic [NUM_CH*VOL_W-1:0] vol;
  logic [NUM_CH-1:0]       force_on;
  logic [NUM_HP-1:0]       hp_en;
  logic [NUM_HP-1:0]       hp_held;
  logic [NUM_CH-1:0]       gated;
  logic                    unused_tick;

  assign unused_tick = ^div_tick[NUM_HP-1:0];

  snd_ctrl_regs #(
    .NUM_CH(NUM_CH), .VOL_W(VOL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vol(vol), .force_on(force_on), .hp_en(hp_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c < NUM_HP) begin : g_hp
      // filtered channel c is sampled by the divider pulse of channel c+2
      snd_hp_filter u_hp (
        .clk(clk), .rst_n(rst_n), .audio_in(ch_audio[c]),
        .sample_tick(div_tick[c+NUM_HP]), .enable(hp_en[c]),
        .audio_out(gated[c]), .held(hp_held[c])
      );
    end else begin : g_plain
      assign gated[c] = ch_audio[c];
    end
    snd_vol_gate #(.VOL_W(VOL_W)) u_vol (
      .audio_in(gated[c]), .force_on(force_on[c]),
      .vol(vol[c*VOL_W +: VOL_W]), .level(ch_level[c*VOL_W +: VOL_W])
    );
  end
endmodule

// File: rtl/snd_out_stage_chk.sv
module snd_out_stage_chk #(
  parameter int NUM_CH = 4,
  parameter int VOL_W  = 4,
  parameter int NUM_HP = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       ch_audio,
  input logic [NUM_CH-1:0]       div_tick,
  input logic [NUM_CH*VOL_W-1:0] ch_level,
  input logic [NUM_CH*VOL_W-1:0] vol,
  input logic [NUM_CH-1:0]       force_on,
  input logic [NUM_HP-1:0]       hp_en,
  input logic [NUM_HP-1:0]       hp_held
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R4
    vol_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_on[c] |-> ch_level[c*VOL_W +: VOL_W] == vol[c*VOL_W +: VOL_W]);
    // R9
    level_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_level[c*VOL_W +: VOL_W] != '0 |-> ch_level[c*VOL_W +: VOL_W] == vol[c*VOL_W +: VOL_W]);
    if (c >= NUM_HP) begin : g_nf
      // R2
      silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_on[c] && !ch_audio[c]) |-> ch_level[c*VOL_W +: VOL_W] == '0);
    end
  end
  for (genvar k = 0; k < NUM_HP; k++) begin : g_k
    // R5
    hp_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_en[k] && div_tick[k+NUM_HP]) |=> hp_held[k] == $past(ch_audio[k]));
    // R7
    hp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hp_en[k] && div_tick[k+NUM_HP]) |=> $stable(hp_held[k]));
  end
endmodule

bind snd_out_stage snd_out_stage_chk #(
  .NUM_CH(NUM_CH), .VOL_W(VOL_W), .NUM_HP(snd_out_pkg::NUM_HP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_audio(ch_audio), .div_tick(div_tick),
  .ch_level(ch_level), .vol(vol), .force_on(force_on), .hp_en(hp_en),
  .hp_held(hp_held)
);

// File: tb/snd_out_stage_test.sv
module snd_out_stage_test;
  logic        clk, rst_n, wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [3:0]  ch_audio, div_tick;
  logic [15:0] ch_level;

  int checks = 0, errors = 0;
  logic [3:0] m_vol [4];
  logic [3:0] m_frc, m_lvl;
  logic [1:0] m_en, m_hp;

  snd_out_stage uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_audio(ch_audio), .div_tick(div_tick),
    .ch_level(ch_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input int c, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ch%0d level actual %0d expected %0d", tag, c, act, exp);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 3'd4) begin m_vol[a] = d[3:0]; m_frc[a] = d[4]; end
    else if (a == 3'd4) begin m_en[0] = d[2]; m_en[1] = d[1]; end
  endtask

  task automatic step(input logic [3:0] aud, input logic [3:0] tk, input string tag);
    ch_audio = aud; div_tick = tk;
    #1;
    for (int c = 0; c < 4; c++) begin
      logic a;
      a = aud[c];
      if (c < 2 && m_en[c]) a = a ^ m_hp[c];
      m_lvl = (a | m_frc[c]) ? m_vol[c] : 4'd0;
      check(tag, c, ch_level[c*4 +: 4], m_lvl);
    end
    @(posedge clk);
    if (m_en[0] && tk[2]) m_hp[0] = aud[0];
    if (m_en[1] && tk[3]) m_hp[1] = aud[1];
    @(negedge clk);
    div_tick = 4'd0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ch_audio = 4'hF; div_tick = 4'd0;
    for (int c = 0; c < 4; c++) m_vol[c] = 4'd0;
    m_frc = '0; m_en = '0; m_hp = '0;
    #9;
    for (int c = 0; c < 4; c++) check("R1", c, ch_level[c*4 +: 4], 4'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    step(4'hF, 4'hF, "R1");

    // volume, force and audio sweep, filters off (R2 R3 R4 R9)
    for (int c = 0; c < 4; c++)
      for (int v = 0; v < 16; v++)
        for (int f = 0; f < 2; f++) begin
          wr(3'(c), {3'b000, f[0], v[3:0]});
          for (int a = 0; a < 2; a++)
            step(a[0] ? 4'hF : 4'h0, 4'(v * 3 + a),
                 (v == 0 || v == 15) ? "R9" : (f[0] ? "R4" : (a[0] ? "R3" : "R2")));
        end

    wr(3'd0, 8'h0F); wr(3'd1, 8'h09); wr(3'd2, 8'h05); wr(3'd3, 8'h0C);
    // R5 channel 1 filter alone
    wr(3'd4, 8'h04);
    for (int i = 0; i < 32; i++) step(4'(i ^ (i >> 2)), 4'((i * 7) ^ (i >> 1)), "R5");
    // R6 channel 2 filter alone
    wr(3'd4, 8'h02);
    for (int i = 0; i < 32; i++) step(4'((i * 5) ^ (i >> 1)), 4'((i * 11) ^ i >> 2), "R6");
    // R8 both filters on, plain channels under all pulses
    wr(3'd4, 8'h06);
    for (int i = 0; i < 32; i++) step(4'(i * 13), 4'hF, "R8");
    // R4 force with filters on
    wr(3'd0, 8'h1A); wr(3'd1, 8'h17);
    for (int i = 0; i < 8; i++) step(4'(i * 3), 4'(i), "R4");
    wr(3'd0, 8'h0F); wr(3'd1, 8'h09);
    // R7 hold while disabled
    step(4'h3, 4'hC, "R7");               // load 1 into both samples
    wr(3'd4, 8'h00);
    for (int i = 0; i < 6; i++) step(4'(i), 4'hF, "R7");
    wr(3'd4, 8'h06);
    step(4'h0, 4'h0, "R7");               // held 1 shows as level
    step(4'h3, 4'h0, "R7");
    // R10 writes to unused addresses
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    step(4'h0, 4'h0, "R10");
    step(4'hF, 4'h0, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule